// File: doc/BRIEF.md
# Phy Manager State Machine for a Storage Port Layer

This block follows one phy of a serial-attached storage port through three situations: nothing pending, a connection request waiting on the link layer, and an open connection. It takes single-cycle confirmations from the link layer, moves between those situations, and sends single-cycle messages to the port layer's open-connection controller. It also emits a terminate-all-operations pulse when a hard reset is seen.

Confirmations race each other when a link goes down. The phy-disabled or connection-closed confirmation normally lands first and returns the machine to Idle. The hard-reset-received confirmation then finds the machine already in Idle. Baseline Idle ignores that confirmation, so outstanding work is never terminated. A configuration input, `fix_mode_en`, makes Idle act on the hard reset so that the reset is not lost.

All pins are plain control or status pulses with no data path, so there is no valid/ready handshake and no back-pressure. Every output is registered and reflects the inputs sampled at the previous rising clock edge.

Top module: `phy_mgr_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts `pm_state` at Idle (code 0) and drives every message output and `term_all_ops` low.
- R2: In Idle, `conn_req` moves `pm_state` to Request-Wait (code 1) on the next cycle, with no message.
- R3: In Request-Wait, `cfm_retry_open` sends a one-cycle `msg_retry_open` and returns to Idle.
- R4: In Request-Wait, `cfm_unable` sends a one-cycle `msg_unable` and returns to Idle.
- R5: In Request-Wait, `cfm_phy_disabled` returns to Idle with no message.
- R6: In Request-Wait, `open_done` moves to Connected (code 2) with no message.
- R7: In Connected, `cfm_conn_closed` or `cfm_phy_disabled` sends a one-cycle `msg_conn_closed` and returns to Idle.
- R8: In Request-Wait or Connected, `cfm_hard_reset` pulses `term_all_ops` for one cycle and returns to Idle, with no other message, whatever else arrives in that cycle.
- R9: In Request-Wait, when several inputs arrive together, `cfm_phy_disabled` wins over `cfm_retry_open`, which wins over `cfm_unable`, which wins over `open_done`.
- R10: With `fix_mode_en` low, `cfm_hard_reset` in Idle has no effect: there is no `term_all_ops`, and a `conn_req` in the same cycle is still taken.
- R11: With `fix_mode_en` high, `cfm_hard_reset` in Idle pulses `term_all_ops` for one cycle, and the machine stays in Idle, ignoring a `conn_req` in the same cycle.
- R12: At most one of `msg_retry_open`, `msg_unable`, `msg_conn_closed` and `term_all_ops` is high in any cycle. Each of them falls on the next cycle when no new event arrives.
- R13: Inputs that do not belong to the current state leave the state unchanged and raise no output. These are `cfm_conn_closed` in Request-Wait, `cfm_retry_open`, `cfm_unable` and `open_done` in Connected, and every confirmation except an enabled hard reset in Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fix_mode_en | input | 1 | Makes Idle act on a hard-reset confirmation |
| conn_req | input | 1 | Connection request pulse from the port layer |
| open_done | input | 1 | Connection-established pulse from the link layer |
| cfm_retry_open | input | 1 | Retry-open confirmation pulse |
| cfm_unable | input | 1 | Unable-to-connect confirmation pulse |
| cfm_phy_disabled | input | 1 | Phy-disabled confirmation pulse |
| cfm_conn_closed | input | 1 | Connection-closed (to idle) confirmation pulse |
| cfm_hard_reset | input | 1 | Hard-reset-received confirmation pulse |
| msg_retry_open | output | 1 | Retry-open message to the open-connection controller |
| msg_unable | output | 1 | Unable-to-connect message to the controller |
| msg_conn_closed | output | 1 | Connection-closed message to the controller |
| term_all_ops | output | 1 | Terminate-all-operations pulse |
| pm_state | output | 2 | Current state: 0 Idle, 1 Request-Wait, 2 Connected |

## Verification
A hard-reset confirmation can land in the same cycle as a phy-disabled, retry, unable, close or request input. Those events compete for the state update and for the single message slot. The bench drives the machine into each of the three states under both settings of `fix_mode_en`. It then applies every one of the 128 combinations of the seven event inputs in one cycle. It judges the next state and the one active output against the priority order in R8 to R11, then checks that the pulse has fallen one cycle later.

// File: rtl/phy_mgr_pkg.sv
package phy_mgr_pkg;
  localparam int STATE_W = 2;
  localparam int EVENT_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PM_IDLE = 2'd0,
    PM_WAIT = 2'd1,
    PM_CONN = 2'd2
  } pm_state_e;

  typedef enum logic [EVENT_W-1:0] {
    EV_NONE   = 3'd0,
    EV_HRESET = 3'd1,
    EV_PHYOFF = 3'd2,
    EV_RETRY  = 3'd3,
    EV_UNABLE = 3'd4,
    EV_CLOSED = 3'd5,
    EV_ACCEPT = 3'd6,
    EV_REQ    = 3'd7
  } pm_event_e;

  typedef struct packed {
    logic term;
    logic closed;
    logic unable;
    logic retry;
  } pm_msg_t;

  typedef struct packed {
    logic req;
    logic accept;
    logic retry;
    logic unable;
    logic phyoff;
    logic closed;
    logic hreset;
  } pm_in_t;
endpackage

// File: rtl/phy_mgr_evt_select.sv
module phy_mgr_evt_select
  import phy_mgr_pkg::*;
(
  input  pm_state_e state,
  input  logic      fix_en,
  input  pm_in_t    ev_in,
  output pm_event_e ev_win
);
  // Picks the single event that acts this cycle; inputs foreign to the state drop out.
  always_comb begin
    ev_win = EV_NONE;
    unique case (state)
      PM_IDLE: begin
        if (ev_in.hreset && fix_en) ev_win = EV_HRESET;
        else if (ev_in.req)         ev_win = EV_REQ;
      end
      PM_WAIT: begin
        if (ev_in.hreset)       ev_win = EV_HRESET;
        else if (ev_in.phyoff)  ev_win = EV_PHYOFF;
        else if (ev_in.retry)   ev_win = EV_RETRY;
        else if (ev_in.unable)  ev_win = EV_UNABLE;
        else if (ev_in.accept)  ev_win = EV_ACCEPT;
      end
      PM_CONN: begin
        if (ev_in.hreset)       ev_win = EV_HRESET;
        else if (ev_in.phyoff)  ev_win = EV_PHYOFF;
        else if (ev_in.closed)  ev_win = EV_CLOSED;
      end
      default: ev_win = EV_NONE;
    endcase
  end
endmodule

// File: rtl/phy_mgr_step.sv
module phy_mgr_step
  import phy_mgr_pkg::*;
(
  input  pm_state_e state,
  input  pm_event_e ev_win,
  output pm_state_e state_nx,
  output pm_msg_t   msg_nx
);
  always_comb begin
    state_nx = state;
    msg_nx   = '0;
    unique case (ev_win)
      EV_HRESET: begin
        state_nx    = PM_IDLE;
        msg_nx.term = 1'b1;
      end
      EV_PHYOFF: begin
        state_nx      = PM_IDLE;
        msg_nx.closed = (state == PM_CONN);
      end
      EV_RETRY: begin
        state_nx     = PM_IDLE;
        msg_nx.retry = 1'b1;
      end
      EV_UNABLE: begin
        state_nx      = PM_IDLE;
        msg_nx.unable = 1'b1;
      end
      EV_CLOSED: begin
        state_nx      = PM_IDLE;
        msg_nx.closed = 1'b1;
      end
      EV_ACCEPT: state_nx = PM_CONN;
      EV_REQ:    state_nx = PM_WAIT;
      default:   state_nx = state;
    endcase
  end
endmodule

// File: rtl/phy_mgr_fsm.sv
module phy_mgr_fsm
  import phy_mgr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fix_mode_en,
  input  logic               conn_req,
  input  logic               open_done,
  input  logic               cfm_retry_open,
  input  logic               cfm_unable,
  input  logic               cfm_phy_disabled,
  input  logic               cfm_conn_closed,
  input  logic               cfm_hard_reset,
  output logic               msg_retry_open,
  output logic               msg_unable,
  output logic               msg_conn_closed,
  output logic               term_all_ops,
  output logic [STATE_W-1:0] pm_state
);
  pm_state_e state_q, state_nx;
  pm_msg_t   msg_q, msg_nx;
  pm_event_e ev_win;
  pm_in_t    ev_in;

  assign ev_in = '{req:    conn_req,
                   accept: open_done,
                   retry:  cfm_retry_open,
                   unable: cfm_unable,
                   phyoff: cfm_phy_disabled,
                   closed: cfm_conn_closed,
                   hreset: cfm_hard_reset};

  phy_mgr_evt_select u_sel (
    .state  (state_q),
    .fix_en (fix_mode_en),
    .ev_in  (ev_in),
    .ev_win (ev_win)
  );

  phy_mgr_step u_step (
    .state    (state_q),
    .ev_win   (ev_win),
    .state_nx (state_nx),
    .msg_nx   (msg_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PM_IDLE;
      msg_q   <= '0;
    end else begin
      state_q <= state_nx;
      msg_q   <= msg_nx;
    end
  end

  assign msg_retry_open  = msg_q.retry;
  assign msg_unable      = msg_q.unable;
  assign msg_conn_closed = msg_q.closed;
  assign term_all_ops    = msg_q.term;
  assign pm_state        = state_q;
endmodule

// File: rtl/phy_mgr_fsm_chk.sv
module phy_mgr_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       fix_mode_en,
  input logic       conn_req,
  input logic       cfm_hard_reset,
  input logic       msg_retry_open,
  input logic       msg_unable,
  input logic       msg_conn_closed,
  input logic       term_all_ops,
  input logic [1:0] pm_state
);
  assert_one_output_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({msg_retry_open, msg_unable, msg_conn_closed, term_all_ops}));

  assert_term_lands_idle_R8: assert property (@(posedge clk) disable iff (rst)
    term_all_ops |-> pm_state == 2'd0);

  assert_retry_from_wait_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_retry_open) |-> (pm_state == 2'd0 && $past(pm_state) == 2'd1));

  assert_unable_from_wait_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_unable) |-> (pm_state == 2'd0 && $past(pm_state) == 2'd1));

  assert_closed_from_conn_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_conn_closed) |-> (pm_state == 2'd0 && $past(pm_state) == 2'd2));

  assert_idle_hr_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'd0 && cfm_hard_reset && !fix_mode_en) |=> !term_all_ops);

  assert_idle_hr_fixed_R11: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'd0 && cfm_hard_reset && fix_mode_en) |=> (term_all_ops && pm_state == 2'd0));

  assert_req_to_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'd0 && conn_req && !(cfm_hard_reset && fix_mode_en)) |=> pm_state == 2'd1);
endmodule

bind phy_mgr_fsm phy_mgr_fsm_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .fix_mode_en     (fix_mode_en),
  .conn_req        (conn_req),
  .cfm_hard_reset  (cfm_hard_reset),
  .msg_retry_open  (msg_retry_open),
  .msg_unable      (msg_unable),
  .msg_conn_closed (msg_conn_closed),
  .term_all_ops    (term_all_ops),
  .pm_state        (pm_state)
);

// File: tb/phy_mgr_fsm_tb.sv
module phy_mgr_fsm_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fix_mode_en = 1'b0;
  logic [6:0] ev = '0; // 0 req,1 accept,2 retry,3 unable,4 phyoff,5 closed,6 hreset
  logic msg_retry_open, msg_unable, msg_conn_closed, term_all_ops;
  logic [1:0] pm_state;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgr_fsm u_dut (
    .clk              (clk),
    .rst              (rst),
    .fix_mode_en      (fix_mode_en),
    .conn_req         (ev[0]),
    .open_done        (ev[1]),
    .cfm_retry_open   (ev[2]),
    .cfm_unable       (ev[3]),
    .cfm_phy_disabled (ev[4]),
    .cfm_conn_closed  (ev[5]),
    .cfm_hard_reset   (ev[6]),
    .msg_retry_open   (msg_retry_open),
    .msg_unable       (msg_unable),
    .msg_conn_closed  (msg_conn_closed),
    .term_all_ops     (term_all_ops),
    .pm_state         (pm_state)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int exp_st, input logic [3:0] exp_m);
    logic [3:0] act_m;
    act_m = {term_all_ops, msg_conn_closed, msg_unable, msg_retry_open};
    checks++;
    if (pm_state !== exp_st[1:0] || act_m !== exp_m) begin
      errors++;
      $display("FAIL %s: state=%0d msgs=%b expected state=%0d msgs=%b",
               tag, pm_state, act_m, exp_st, exp_m);
    end
  endtask

  // msgs as {term, closed, unable, retry}
  function automatic void model(input int st, input logic fix, input logic [6:0] v,
                                output int nst, output logic [3:0] m, output string tag);
    logic req, acc, rty, una, phy, cls, hr;
    {hr, cls, phy, una, rty, acc, req} = v;
    nst = st; m = 4'b0000; tag = "R13";
    if (st == 0) begin
      if (hr && fix) begin nst = 0; m = 4'b1000; tag = "R11"; end
      else if (req) begin nst = 1; tag = hr ? "R10" : "R2"; end
      else tag = hr ? "R10" : "R13";
    end else if (st == 1) begin
      if (hr) begin nst = 0; m = 4'b1000; tag = "R8"; end
      else if (phy) begin nst = 0; tag = (rty | una | acc) ? "R9" : "R5"; end
      else if (rty) begin nst = 0; m = 4'b0001; tag = (una | acc) ? "R9" : "R3"; end
      else if (una) begin nst = 0; m = 4'b0010; tag = acc ? "R9" : "R4"; end
      else if (acc) begin nst = 2; tag = "R6"; end
    end else begin
      if (hr) begin nst = 0; m = 4'b1000; tag = "R8"; end
      else if (phy | cls) begin nst = 0; m = 4'b0100; tag = "R7"; end
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int fx = 0; fx < 2; fx++) begin
      for (int st = 0; st < 3; st++) begin
        for (int v = 0; v < 128; v++) begin
          int nst;
          logic [3:0] em;
          string tag;
          rst = 1'b1; ev = '0; fix_mode_en = fx[0];
          step(); step();
          rst = 1'b0;
          check("R1", 0, 4'b0000);
          if (st >= 1) begin ev = 7'b0000001; step(); end
          if (st == 2) begin ev = 7'b0000010; step(); end
          ev = '0;
          model(st, fx[0], v[6:0], nst, em, tag);
          ev = v[6:0];
          step();
          check(tag, nst, em);
          ev = '0;
          step();
          check("R12", nst, 4'b0000);
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule